// File: doc/BRIEF.md
# Eight-Point Inverse DCT Stream Coprocessor

This block computes a one-dimensional, eight-point inverse discrete cosine transform for a host processor. It is attached through two simplex FIFO links. The inbound link offers a data word with an "exists" flag, and the block pulls a word by pulsing a read strobe. The outbound link reports a "full" flag, and the block pushes a word by driving the data bus with a write strobe.

The host sends eight signed 16-bit coefficients. The block collects them and forms all eight output samples at once, using sixty-four constant multipliers with 12-bit fractional cosine weights. The rounded 16-bit results are then returned on the outbound link in index order. A two-dimensional transform can be built from two of these blocks with a transpose between them.

Work on one group finishes before the next group starts. The block does not read another word until all eight results of the current group have been written.

Top module: `idct8_stream`

## Requirements
- R1: Reset is synchronous and active low. After reset the block strobes neither link until inbound data is offered. Any words of a partly collected group are dropped, and the next word read becomes index 0 of a fresh group.
- R2: `in_rd` is high only in cycles where `in_exists` is high. Each cycle with `in_rd` high consumes the word on `in_data`.
- R3: A group is exactly eight inbound words. The word read in position n of the group (n = 0..7, in arrival order) is coefficient x(n).
- R4: Once the eighth word of a group has been read, `in_rd` stays low until the eighth result of that group has been written. `out_wr` is never high for a group that has not yet received its eight words.
- R5: `out_wr` is never high in a cycle where `out_full` is high.
- R6: The first result can be written in the second cycle after the cycle that read the eighth word. Results leave in the order y(0) to y(7), one in each cycle where `out_full` is low.
- R7: y(k) = floor((S(k) + 2048) / 4096), kept in its low 16 bits as two's complement (values wrap, no saturation). Here S(k) = sum over n of C(k,n)·x(n), and C(k,n) = round(4096·c(n)·cos((2k+1)nπ/16)), with c(0) = 1/(2√2) and c(n) = 1/2 otherwise.
- R8: A group whose only non-zero word is x(0) returns eight equal results, each (1448·x(0) + 2048) >> 12 using an arithmetic shift.
- R9: While `out_full` holds the block back, no result is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_exists | input | 1 | Inbound FIFO holds at least one word |
| in_data | input | 16 | Inbound word at the head of the FIFO, signed coefficient |
| in_rd | output | 1 | Consume the head word of the inbound FIFO this cycle |
| out_full | input | 1 | Outbound FIFO cannot take a word this cycle |
| out_data | output | 16 | Result word, signed sample |
| out_wr | output | 1 | Push `out_data` into the outbound FIFO this cycle |

## Verification
The bench places a single impulse at every input position, at amplitudes that include both 16-bit extremes. A design with a swapped cosine weight, a wrong sign in the symmetry folding, or coefficients stored in the wrong slot returns wrong samples only for particular (k, n) pairs, which this sweep exposes. Pseudo-random groups with all-maximum inputs are compared with a bench model that uses real-valued cosines; these catch truncation used in place of rounding, and a logical shift or an accumulator too narrow to handle wrap. Random gaps on the inbound link and random full periods on the outbound link would catch a design that writes into a full FIFO, skips or repeats a result during a stall, or starts reading the next group early. A reset in the middle of a group would catch a design that keeps the stale word count and returns a transform built from mixed groups.

// File: rtl/idct_pkg.sv
// Package: shared sizes, phase type and the cosine weight table for the
// eight-point inverse DCT. The weights are computed, not listed, and are
// valid only for an eight-point transform with 12 fractional bits.
package idct_pkg;

    localparam int PTS    = 8;
    localparam int IDX_W  = $clog2(PTS);
    localparam int SMP_W  = 16;
    localparam int FRAC_W = 12;
    localparam int COEF_W = FRAC_W + 1;
    localparam int ACC_W  = SMP_W + COEF_W + IDX_W;

    typedef enum logic [1:0] {
        PH_GATHER = 2'd0,
        PH_CALC   = 2'd1,
        PH_SEND   = 2'd2
    } phase_e;

    // round(4096 * 0.5 * cos(m*pi/16)) for m = 0..8
    function automatic logic signed [COEF_W-1:0] half_cos(input int m);
        case (m)
            0:       half_cos = 13'sd2048;
            1:       half_cos = 13'sd2009;
            2:       half_cos = 13'sd1892;
            3:       half_cos = 13'sd1703;
            4:       half_cos = 13'sd1448;
            5:       half_cos = 13'sd1138;
            6:       half_cos = 13'sd784;
            7:       half_cos = 13'sd400;
            default: half_cos = 13'sd0;
        endcase
    endfunction

    // Weight for output k, input n, folded onto the first quadrant.
    function automatic logic signed [COEF_W-1:0] basis(input int k, input int n);
        int a;
        if (n == 0) begin
            basis = 13'sd1448;
        end else begin
            a = ((2 * k + 1) * n) % 32;
            if (a > 16) a = 32 - a;
            if (a <= 8) basis = half_cos(a);
            else        basis = -half_cos(16 - a);
        end
    endfunction

endpackage

// File: rtl/idct_gather.sv
// Module: idct_gather
// Pulls words from the inbound FIFO link while enabled and stores them by
// arrival position. Raises last in the cycle that reads the final word of
// a group. Assumes in_data is valid whenever exists is high.
module idct_gather #(
    parameter int PTS   = idct_pkg::PTS,
    parameter int SMP_W = idct_pkg::SMP_W,
    localparam int IDX_W = $clog2(PTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      exists,
    input  logic [SMP_W-1:0]          din,
    output logic                      rd,
    output logic                      last,
    output logic [PTS-1:0][SMP_W-1:0] vec
);

    logic [IDX_W-1:0] slot;

    // Read whenever collecting and the FIFO has data.
    always_comb begin
        rd   = en && exists;
        last = rd && (slot == IDX_W'(PTS - 1));
    end

    // Store each word in its slot and advance the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            vec  <= '0;
        end else if (rd) begin
            vec[slot] <= din;
            slot      <= last ? '0 : slot + 1'b1;
        end
    end

endmodule

// File: rtl/idct_mac.sv
// Module: idct_mac
// Forms all eight outputs in parallel: 64 constant products, summed per
// output, rounded and shifted right by the fraction width. Results wrap to
// the sample width. Registered on load. Assumes vec is stable when load is high.
module idct_mac #(
    parameter int PTS    = idct_pkg::PTS,
    parameter int SMP_W  = idct_pkg::SMP_W,
    parameter int FRAC_W = idct_pkg::FRAC_W,
    localparam int COEF_W = FRAC_W + 1,
    localparam int ACC_W  = SMP_W + COEF_W + $clog2(PTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [PTS-1:0][SMP_W-1:0] vec,
    output logic [PTS-1:0][SMP_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

    logic [PTS-1:0][SMP_W-1:0] y_comb;

    for (genvar k = 0; k < PTS; k++) begin : g_out
        logic signed [ACC_W-1:0] prod [PTS];
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] shifted;

        for (genvar n = 0; n < PTS; n++) begin : g_term
            localparam logic signed [COEF_W-1:0] W = idct_pkg::basis(k, n);
            logic signed [SMP_W-1:0] xs;
            assign xs      = vec[n];
            assign prod[n] = ACC_W'(xs) * ACC_W'(W);
        end

        // Sum the products of this output with the rounding offset.
        always_comb begin
            acc = RND;
            for (int n = 0; n < PTS; n++) acc = acc + prod[n];
            shifted = acc >>> FRAC_W;
        end

        assign y_comb[k] = shifted[SMP_W-1:0];
    end

    // Capture the full result vector in the compute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    res <= '0;
        else if (load) res <= y_comb;
    end

endmodule

// File: rtl/idct_emit.sv
// Module: idct_emit
// Pushes stored results to the outbound FIFO link in index order, one per
// cycle when the link is not full. Raises last with the final write.
// Assumes res is stable while go is high.
module idct_emit #(
    parameter int PTS   = idct_pkg::PTS,
    parameter int SMP_W = idct_pkg::SMP_W,
    localparam int IDX_W = $clog2(PTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      full,
    input  logic [PTS-1:0][SMP_W-1:0] res,
    output logic                      wr,
    output logic [SMP_W-1:0]          data,
    output logic                      last
);

    logic [IDX_W-1:0] idx;

    // Write only when sending and the FIFO has room.
    always_comb begin
        wr   = go && !full;
        data = res[idx];
        last = wr && (idx == IDX_W'(PTS - 1));
    end

    // Step to the next result after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx <= '0;
        else if (wr) idx <= last ? '0 : idx + 1'b1;
    end

endmodule

// File: rtl/idct8_stream.sv
// Module: idct8_stream (top)
// Eight-point inverse DCT coprocessor between two FIFO links. The phases are
// gather eight words, compute for one cycle, then send eight results.
// Phases never overlap. Assumes standard FIFO flag semantics on both links.
module idct8_stream #(
    parameter int PTS    = idct_pkg::PTS,
    parameter int SMP_W  = idct_pkg::SMP_W,
    parameter int FRAC_W = idct_pkg::FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_exists,
    input  logic [SMP_W-1:0] in_data,
    output logic             in_rd,
    input  logic             out_full,
    output logic [SMP_W-1:0] out_data,
    output logic             out_wr
);

    import idct_pkg::*;

    phase_e                    phase;
    logic                      gath_last;
    logic                      emit_last;
    logic [PTS-1:0][SMP_W-1:0] coefs;
    logic [PTS-1:0][SMP_W-1:0] results;

    idct_gather #(.PTS(PTS), .SMP_W(SMP_W)) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (phase == PH_GATHER),
        .exists (in_exists),
        .din    (in_data),
        .rd     (in_rd),
        .last   (gath_last),
        .vec    (coefs)
    );

    idct_mac #(.PTS(PTS), .SMP_W(SMP_W), .FRAC_W(FRAC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (phase == PH_CALC),
        .vec   (coefs),
        .res   (results)
    );

    idct_emit #(.PTS(PTS), .SMP_W(SMP_W)) u_emit (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (phase == PH_SEND),
        .full  (out_full),
        .res   (results),
        .wr    (out_wr),
        .data  (out_data),
        .last  (emit_last)
    );

    // Phase sequencer: gather, compute, send, then gather again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_GATHER;
        end else begin
            case (phase)
                PH_GATHER: if (gath_last) phase <= PH_CALC;
                PH_CALC:   phase <= PH_SEND;
                PH_SEND:   if (emit_last) phase <= PH_GATHER;
                default:   phase <= PH_GATHER;
            endcase
        end
    end

endmodule

// File: rtl/idct8_stream_chk.sv
// Module: idct8_stream_chk
// Protocol checker bound to idct8_stream. It counts reads and writes per
// group at the ports and checks the link rules against those counts.
module idct8_stream_chk #(
    parameter int PTS = 8,
    localparam int CW = $clog2(PTS) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic in_exists,
    input logic in_rd,
    input logic out_full,
    input logic out_wr
);

    logic [CW-1:0] rd_cnt;
    logic [CW-1:0] wr_cnt;

    // Track words read and written in the current group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else if (out_wr && wr_cnt == CW'(PTS - 1)) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else begin
            if (in_rd)  rd_cnt <= rd_cnt + 1'b1;
            if (out_wr) wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_read_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> in_exists);

    assert_group_of_eight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> (rd_cnt < CW'(PTS)));

    assert_write_after_gather_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (rd_cnt == CW'(PTS)));

    assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !out_wr);

endmodule

bind idct8_stream idct8_stream_chk #(.PTS(PTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_exists (in_exists),
    .in_rd     (in_rd),
    .out_full  (out_full),
    .out_wr    (out_wr)
);

// File: tb/idct8_stream_tb.sv
// Bench for idct8_stream: FIFO link models, real-valued reference transform,
// impulse sweep over every position, DC, random and stall scenarios.
module idct8_stream_tb;

    localparam int CLK_PERIOD = 10;
    localparam int QD = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_exists = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_full = 1'b0;
    wire         in_rd;
    wire         out_wr;
    wire  [15:0] out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    idct8_stream u_dut (
        .clk(clk), .rst_n(rst_n), .in_exists(in_exists), .in_data(in_data),
        .in_rd(in_rd), .out_full(out_full), .out_data(out_data), .out_wr(out_wr)
    );

    int checks = 0, fails = 0;
    logic [15:0] qin [QD];
    logic [15:0] qexp [QD];
    string       etag [QD];
    int q_wr = 0, q_rd = 0, e_wr = 0, e_rd = 0;
    int full_mode = 0, gap_mode = 0;
    int cyc = 0, grp_rd = 0, grp_wr = 0, c8 = 0;
    bit pending_pop = 0;
    logic [15:0] mlfsr = 16'hACE1;
    logic [31:0] dseed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int coef(input int k, input int n);
        real v;
        if (n == 0) v = 1.0 / (2.0 * $sqrt(2.0));
        else        v = 0.5 * $cos((2 * k + 1) * n * 3.14159265358979 / 16.0);
        v = v * 4096.0;
        if (v >= 0.0) return $rtoi($floor(v + 0.5));
        else          return -$rtoi($floor(-v + 0.5));
    endfunction

    task automatic push_group(input logic signed [15:0] x [8], input string tag);
        for (int k = 0; k < 8; k++) begin
            longint s = 0;
            for (int n = 0; n < 8; n++) s += longint'(x[n]) * coef(k, n);
            s = (s + 2048) >>> 12;
            qexp[e_wr] = s[15:0];
            etag[e_wr] = tag;
            e_wr++;
        end
        for (int n = 0; n < 8; n++) begin
            qin[q_wr] = x[n];
            q_wr++;
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic drain();
        while (e_rd < e_wr || q_rd < q_wr) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // Link models and monitor: update flags after negedge, then sample.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (pending_pop) q_rd++;
            pending_pop = 0;
            mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
            in_exists = rst_n && (q_rd < q_wr) && (gap_mode == 0 || mlfsr[0] || mlfsr[7]);
            in_data   = (q_rd < q_wr) ? qin[q_rd] : 16'h0;
            out_full  = (full_mode == 1) ? cyc[0] :
                        (full_mode == 2) ? (mlfsr[2] & mlfsr[5]) : 1'b0;
            #1;
            if (!rst_n) begin
                grp_rd = 0;
                grp_wr = 0;
            end else begin
                if (in_rd) begin
                    chk(in_exists, "R2 read without data", in_rd, 0);
                    chk(grp_rd < 8, "R4 read before group drained", grp_rd, 7);
                    pending_pop = in_exists;
                    grp_rd++;
                    if (grp_rd == 8) c8 = cyc;
                end
                if (out_wr) begin
                    chk(!out_full, "R5 write while full", out_wr, 0);
                    chk(grp_rd == 8, "R4 write before eight reads", grp_rd, 8);
                    if (grp_wr == 0) begin
                        if (full_mode == 0) chk(cyc - c8 == 2, "R6 first write latency", cyc - c8, 2);
                        else                chk(cyc - c8 >= 2, "R6 first write latency", cyc - c8, 2);
                    end
                    if (e_rd < e_wr) begin
                        chk(out_data == qexp[e_rd], etag[e_rd],
                            int'($signed(out_data)), int'($signed(qexp[e_rd])));
                        e_rd++;
                    end else begin
                        chk(0, "R6 unexpected result", int'($signed(out_data)), 0);
                    end
                    grp_wr++;
                    if (grp_wr == 8) begin
                        grp_wr = 0;
                        grp_rd = 0;
                    end
                end
            end
            if (cyc > 150000) begin
                chk(0, "watchdog expired", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic signed [15:0] x [8];
        int amps [6];
        amps = '{1, -1, 1000, -2048, 32767, -32768};

        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle after reset with an empty inbound FIFO
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            chk(in_rd == 1'b0, "R1 read after reset", in_rd, 0);
            chk(out_wr == 1'b0, "R1 write after reset", out_wr, 0);
        end

        // R3: impulse at every position and amplitude
        @(posedge clk);
        for (int n = 0; n < 8; n++) begin
            for (int a = 0; a < 6; a++) begin
                for (int m = 0; m < 8; m++) x[m] = (m == n) ? 16'(amps[a]) : 16'sd0;
                push_group(x, "R3 impulse position");
            end
        end
        drain();

        // R8: DC-only groups
        for (int a = 0; a < 3; a++) begin
            for (int m = 0; m < 8; m++) x[m] = 16'sd0;
            x[0] = (a == 0) ? 16'sd12345 : (a == 1) ? -16'sd3000 : 16'sd7;
            push_group(x, "R8 DC group");
        end
        drain();

        // R7: random groups, inbound gaps, alternating full
        @(posedge clk);
        full_mode = 1;
        gap_mode = 1;
        for (int g = 0; g < 20; g++) begin
            for (int m = 0; m < 8; m++) begin
                dseed = nxt(dseed);
                x[m] = dseed[15:0];
            end
            push_group(x, "R7 random group");
        end
        for (int m = 0; m < 8; m++) x[m] = (m[0]) ? -16'sd32768 : 16'sd32767;
        push_group(x, "R7 extreme wrap");
        for (int m = 0; m < 8; m++) x[m] = 16'sd32767;
        push_group(x, "R7 extreme wrap");
        drain();

        // R9: random stalls on the outbound link
        @(posedge clk);
        full_mode = 2;
        for (int g = 0; g < 20; g++) begin
            for (int m = 0; m < 8; m++) begin
                dseed = nxt(dseed);
                x[m] = dseed[15:0];
            end
            push_group(x, "R9 stalled group");
        end
        drain();

        // R1: reset in the middle of a group discards it
        @(posedge clk);
        full_mode = 0;
        gap_mode = 0;
        for (int m = 0; m < 5; m++) begin
            qin[q_wr] = 16'(1000 * (m + 1));
            q_wr++;
        end
        while (q_rd < q_wr) @(posedge clk);
        @(posedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++) x[m] = 16'(100 * m - 350);
        push_group(x, "R1 group after mid-group reset");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule